// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block sits between eight peripheral request lines and a single interrupt input of a processor. It samples the request lines on every clock edge, finds the most urgent one under a fixed ranking (line 0 most urgent, line 7 least), and raises one interrupt output toward the processor. When the processor answers with an acknowledge pulse, the block returns an 8-bit vector that identifies the winning line. It also records that line as being serviced.

The block keeps one in-service bit per line, so handlers can nest. A new request reaches the processor only if it strictly outranks every level already in service. An end-of-service pulse from the handler retires the most urgent in-service level. Lower levels that were preempted then become the active ones again.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is low, and after it is released with no request pending, `cpu_int` is 0, `vec_valid` is 0 and `vec_out` is 0. No line is pending and none is in service.
- R2: Request lines are level-sensitive. A line that is high at a rising edge is pending after that edge. A line that is low at an edge is no longer pending after it, so a request withdrawn before acknowledge drops `cpu_int`.
- R3: Ranking is fixed. Among pending lines, the one with the lowest index wins.
- R4: An acknowledge sampled at an edge while `cpu_int` is 1 makes `vec_valid` 1 for the following cycle. `vec_out` then equals `{vec_base, n}`, where `vec_base` occupies bits 7:3 (sampled at that edge) and the 3-bit winning line number `n` occupies bits 2:0.
- R5: At that acknowledge edge, the winning line stops being pending and becomes in service. With no more urgent line pending, `cpu_int` is 0 afterwards.
- R6: `cpu_int` is 1 only when the most urgent pending line has a strictly lower index than the most urgent in-service line, or when nothing is in service. A request of equal or lower urgency than an in-service level is held back.
- R7: An end-of-service pulse sampled at an edge clears only the most urgent in-service bit. Less urgent nested levels stay in service.
- R8: An acknowledge sampled while `cpu_int` is 0 produces no vector and leaves the in-service state unchanged.
- R9: Whenever `vec_valid` is 0, `vec_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_lines | input | 8 | Level-sensitive request lines; bit 0 is most urgent |
| vec_base | input | 5 | Upper five bits of every returned vector |
| int_ack | input | 1 | Acknowledge pulse from the processor |
| eos | input | 1 | End-of-service pulse from the handler |
| cpu_int | output | 1 | Interrupt request toward the processor |
| vec_valid | output | 1 | Vector on `vec_out` is valid this cycle |
| vec_out | output | 8 | Vector of the acknowledged line |

## Verification
The assertions assume that acknowledge and end-of-service come as pulses from a well-behaved processor. The end-of-service count check only applies on edges without an acknowledge. The spurious-acknowledge check only applies on edges without an end-of-service. The stimulus never drives both pulses in the same cycle, and it raises each pulse for exactly one cycle. Request lines change only at falling edges, well away from the sampling edge. Between test steps the bench returns every line to zero and retires every in-service level it created, so each sweep point starts from an empty state.

// File: rtl/prio_irq_pkg.sv
// Shared defaults for the priority interrupt controller.
// Assumes: line count is a power of two so that the line number fills its field.
package prio_irq_pkg;
    localparam int unsigned PIC_LINES = 8;
    localparam int unsigned PIC_VEC_W = 8;
    localparam int unsigned PIC_IDX_W = $clog2(PIC_LINES);
    localparam int unsigned PIC_BASE_W = PIC_VEC_W - PIC_IDX_W;
endpackage

// File: rtl/pic_first_set.sv
// Finds the lowest-index set bit of a mask (index 0 is most urgent).
// Returns whether any bit is set, its index and a one-hot copy of it.
// Assumes: purely combinational, N >= 2.
module pic_first_set #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  bits,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);
    // Scan from least to most urgent so the most urgent set bit wins last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
        onehot = found ? (N'(1) << idx) : '0;
    end
endmodule

// File: rtl/pic_req_stage.sv
// Pending-request register: samples the level-sensitive request lines each
// edge and drops the bit being granted on the acknowledge edge.
// Assumes: request lines are synchronous to clk.
module pic_req_stage #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] pend_q
);
    // Follow the request levels, masking the line granted this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= irq_in & ~clr_mask;
    end
endmodule

// File: rtl/pic_isr_stage.sv
// In-service register: sets the granted level, clears the most urgent level
// on an end-of-service pulse.
// Assumes: top_mask is one-hot (or zero) and marks the most urgent set bit.
module pic_isr_stage #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_mask,
    input  logic         eos,
    input  logic [N-1:0] top_mask,
    output logic [N-1:0] isr_q
);
    logic [N-1:0] retire_mask;

    // Select the level to retire only when end-of-service is signalled.
    always_comb retire_mask = eos ? top_mask : '0;

    // Apply retirement and the new grant together.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q & ~retire_mask) | set_mask;
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Eight-input priority interrupt controller with nested in-service tracking.
// Ranks pending requests against the most urgent in-service level, raises
// cpu_int, and answers an acknowledge with {vec_base, line} for one cycle.
// Assumes: int_ack and eos are single-cycle pulses synchronous to clk.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter  int unsigned N_LINES = PIC_LINES,
    parameter  int unsigned VEC_W   = PIC_VEC_W,
    localparam int unsigned IDX_W   = $clog2(N_LINES),
    localparam int unsigned BASE_W  = VEC_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_lines,
    input  logic [BASE_W-1:0]  vec_base,
    input  logic               int_ack,
    input  logic               eos,
    output logic               cpu_int,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_out
);
    localparam int unsigned SCANS = 2;  // scan 0: pending, scan 1: in service

    logic [N_LINES-1:0] pend_q;
    logic [N_LINES-1:0] isr_q;
    logic [N_LINES-1:0] grant_mask;

    logic [SCANS-1:0][N_LINES-1:0] scan_bits;
    logic [SCANS-1:0]              scan_found;
    logic [SCANS-1:0][IDX_W-1:0]   scan_idx;
    logic [SCANS-1:0][N_LINES-1:0] scan_oh;

    logic int_now;
    logic take_ack;

    // Route the two masks into the shared scanners.
    always_comb begin
        scan_bits[0] = pend_q;
        scan_bits[1] = isr_q;
    end

    // One priority scanner per mask.
    for (genvar s = 0; s < SCANS; s++) begin : g_scan
        pic_first_set #(.N(N_LINES), .IW(IDX_W)) u_find (
            .bits   (scan_bits[s]),
            .found  (scan_found[s]),
            .idx    (scan_idx[s]),
            .onehot (scan_oh[s])
        );
    end

    // Request outranks in-service level only with a strictly lower index.
    always_comb begin
        int_now    = scan_found[0] && (!scan_found[1] || (scan_idx[0] < scan_idx[1]));
        take_ack   = int_ack && int_now;
        grant_mask = take_ack ? scan_oh[0] : '0;
    end

    pic_req_stage #(.N(N_LINES)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_lines),
        .clr_mask (grant_mask),
        .pend_q   (pend_q)
    );

    pic_isr_stage #(.N(N_LINES)) u_isr (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (grant_mask),
        .eos      (eos),
        .top_mask (scan_oh[1]),
        .isr_q    (isr_q)
    );

    // Register the vector for one cycle after an accepted acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            vec_valid <= take_ack;
            vec_out   <= take_ack ? {vec_base, scan_idx[0]} : '0;
        end
    end

    assign cpu_int = int_now;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
// Property checker for prio_irq_ctrl, attached through bind.
// Assumes: int_ack and eos are pulses; see the brief for input rules.
module prio_irq_ctrl_chk #(
    parameter int unsigned N_LINES = 8,
    parameter int unsigned VEC_W   = 8
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                int_ack,
    input logic                                eos,
    input logic                                cpu_int,
    input logic                                vec_valid,
    input logic [VEC_W-1:0]                    vec_out,
    input logic [VEC_W-$clog2(N_LINES)-1:0]    vec_base,
    input logic [N_LINES-1:0]                  pend_q,
    input logic [N_LINES-1:0]                  isr_q
);
    localparam int unsigned IDX_W = $clog2(N_LINES);

    // R4: upper field of the vector is the base sampled at the acknowledge edge.
    a_r4_vec_base: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> vec_out[VEC_W-1:IDX_W] == $past(vec_base));

    // R5: the line named by the vector is in service.
    a_r5_isr_marked: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> isr_q[vec_out[IDX_W-1:0]]);

    // R8: a vector only follows an acknowledge taken while cpu_int was high.
    a_r8_ack_needs_int: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ($past(int_ack) && $past(cpu_int)));

    // R8: a spurious acknowledge leaves service state and vector idle.
    a_r8_spurious_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !cpu_int && !eos) |=> (!vec_valid && $stable(isr_q)));

    // R7: end-of-service retires exactly one level.
    a_r7_eos_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eos && !int_ack && isr_q != '0) |=>
            ($countones(isr_q) == $countones($past(isr_q)) - 1));

    // R9: idle vector bus reads zero.
    a_r9_vec_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> vec_out == '0);

    // R6: the interrupt output never rises without a pending request.
    a_r6_int_has_pending: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_int |-> pend_q != '0);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_LINES(N_LINES), .VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_ack   (int_ack),
    .eos       (eos),
    .cpu_int   (cpu_int),
    .vec_valid (vec_valid),
    .vec_out   (vec_out),
    .vec_base  (vec_base),
    .pend_q    (pend_q),
    .isr_q     (isr_q)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] irq_lines;
    logic [4:0] vec_base;
    logic       int_ack;
    logic       eos;
    logic       cpu_int;
    logic       vec_valid;
    logic [7:0] vec_out;

    int compared = 0;
    int mismatched = 0;

    always #5 clk = ~clk;

    prio_irq_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .vec_base  (vec_base),
        .int_ack   (int_ack),
        .eos       (eos),
        .cpu_int   (cpu_int),
        .vec_valid (vec_valid),
        .vec_out   (vec_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_ack();
        int_ack = 1'b1;
        step();
        int_ack = 1'b0;
    endtask

    task automatic pulse_eos();
        eos = 1'b1;
        step();
        eos = 1'b0;
    endtask

    function automatic int lowest_set(input logic [7:0] m);
        for (int i = 7; i >= 0; i--) if (m[i]) lowest_set = i;
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; irq_lines = '0; vec_base = '0; int_ack = 1'b0; eos = 1'b0;
        @(negedge clk);
        irq_lines = 8'hFF;
        step(); step();
        // R1: held in reset even with requests present
        chk("R1 cpu_int", cpu_int, 0);
        chk("R1 vec_valid", vec_valid, 0);
        chk("R1 vec_out", vec_out, 0);
        irq_lines = '0;
        step();
        rst_n = 1'b1;
        step();
        chk("R1 cpu_int after release", cpu_int, 0);
        chk("R1 vec_valid after release", vec_valid, 0);

        // Sweep every nonzero request pattern from an empty state.
        for (int p = 1; p < 256; p++) begin
            logic [4:0] base;
            int w;
            base = 5'(p) ^ 5'h15;
            w = lowest_set(8'(p));
            vec_base = base;
            irq_lines = 8'(p);
            step();
            chk("R2 request raises cpu_int", cpu_int, 1);
            pulse_ack();
            chk("R4 vec_valid", vec_valid, 1);
            chk("R3/R4 vector", vec_out, {base, 3'(w)});
            chk("R5 cpu_int after ack", cpu_int, 0);
            irq_lines = '0;
            pulse_eos();
            chk("R9 vec_out idle", vec_out, 0);
            chk("R9 vec_valid idle", vec_valid, 0);
            step();
            chk("R2 no request", cpu_int, 0);
        end

        // Nesting sweep over every ordered pair of lines.
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                logic [4:0] base;
                base = 5'((a * 3 + b) & 31);
                vec_base = base;
                irq_lines = 8'(1 << a);
                step();
                chk("R2 first request", cpu_int, 1);
                pulse_ack();
                chk("R4 first vector", vec_out, {base, 3'(a)});
                irq_lines = 8'(1 << b);
                step();
                chk("R6 nesting rank", cpu_int, (b < a) ? 1 : 0);
                if (b < a) begin
                    pulse_ack();
                    chk("R4 nested vector", vec_out, {base, 3'(b)});
                    chk("R5 nested cpu_int", cpu_int, 0);
                    irq_lines = '0;
                    pulse_eos();
                    irq_lines = 8'(1 << a);
                    step();
                    chk("R7 outer level kept", cpu_int, 0);
                end
                irq_lines = '0;
                step();
                pulse_eos();
                irq_lines = 8'(1 << a);
                step();
                chk("R7 outer level retired", cpu_int, 1);
                irq_lines = '0;
                step();
                chk("R2 withdrawn request", cpu_int, 0);
            end
        end

        // R8: acknowledge with nothing pending.
        pulse_ack();
        chk("R8 spurious vec_valid", vec_valid, 0);
        chk("R8 spurious vec_out", vec_out, 0);
        irq_lines = 8'h80;
        step();
        chk("R8 service state untouched", cpu_int, 1);
        irq_lines = '0;
        step();

        // R8: acknowledge while a request is held back by a more urgent level.
        vec_base = 5'h0A;
        irq_lines = 8'h04;
        step();
        pulse_ack();
        chk("R4 vector line 2", vec_out, {5'h0A, 3'd2});
        irq_lines = 8'h20;
        step();
        chk("R6 line 5 blocked", cpu_int, 0);
        pulse_ack();
        chk("R8 blocked ack no vector", vec_valid, 0);
        pulse_eos();
        chk("R8 line 5 released after eos", cpu_int, 1);
        pulse_ack();
        chk("R4 vector line 5", vec_out, {5'h0A, 3'd5});
        irq_lines = '0;
        pulse_eos();
        step();
        chk("R7 all retired", cpu_int, 0);

        finish_run();
    end
endmodule